// File: doc/BRIEF.md
# Privileged Control Register Bank

This block holds the privileged control state of a processor core: a bank of 64-bit registers addressed by a 6-bit index, with one combinational read port and one write port that commits on the clock edge. Every index has a fixed role. Some indices store the whole word. Some keep only certain bit fields. Some are cleared by any write. Some can only be read, some can only be written, and any index without a role rejects every access. An access that its index does not permit raises a fault flag in the same cycle and has no effect.

Writes to the write-only indices do not store anything. Each one sends a single-cycle pulse to the logic that performs the action, such as a cache flush or a translation-buffer invalidate. That logic lives outside this block. One index serves as a cycle counter. A read of it joins the upper half that software wrote with the lower half of a tick counter that runs freely from reset.

The index map is as follows:
- 0 to 7: scratch
- 8: base address
- 9: performance counter
- 10: exception address
- 11: priority level
- 12: software-interrupt request
- 13 and 14: mode registers
- 15 and 16: trap request and trap enable
- 17 and 18: exception summary and exception mask
- 19: instruction control
- 20 and 21: instruction and data page-table base
- 22: cache test control
- 23 and 24: cache modes
- 25 and 26: instruction and data address-space IDs
- 27: cycle counter
- 28 to 32: read-only
- 33 to 38: write-only strobes
- 39 to 63: unassigned

Top module: `ctl_regbank`

## Requirements
- R1: After reset every readable index reads as zero, `fault` is low and `ctl_pulse` is zero.
- R2: Indices 0 to 9 store all 64 bits of the write data.
- R3: Index 10 stores the write data with bit 1 forced to zero (data AND NOT 2).
- R4: Index 11 keeps mask 0x1f, index 12 keeps mask 0x7fff0, indices 13 and 14 keep mask 0x18, and indices 15 and 16 keep mask 0xf. All other bits read as zero.
- R5: Index 19 keeps mask 0xffffff0300. Indices 20 and 21 keep 0xffffffffc0000000. Index 22 keeps 0x1ffb. Indices 23 and 24 keep 0x3f. Index 25 keeps 0x7f0. Index 26 keeps 0xfe00000000000000.
- R6: Any write to index 17 or 18 clears that register to zero, whatever the write data.
- R7: A write to indices 28 to 32 raises `fault` and changes no register. A read of those indices succeeds and returns zero.
- R8: A read of indices 33 to 38 raises `fault` and returns zero on `rd_data`.
- R9: A write to index 33+k sets `ctl_pulse[k]` high in the cycle after the write, for exactly one cycle. At most one pulse bit is high at a time.
- R10: Any read or write of indices 39 to 63 raises `fault`, and such a write changes no register.
- R11: A read of index 27 returns bits 63:32 of the last value written there in bits 63:32, and a free-running tick count in bits 31:0. The tick count rises by one every clock.
- R12: `fault` is combinational and is high in the same cycle as the offending strobe. `rd_data` is zero whenever `rd_en` is low or the read faults. A read of an index returns the value held before any write to it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, commits on the rising clock edge |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Combinational read data |
| fault | output | 1 | Illegal-access flag, same cycle as the strobe |
| ctl_pulse | output | 6 | One-cycle action pulses, one per write-only index |

## Verification
The bench writes every index with several patterns and then reads the whole bank back, so the masking is checked for each index. A wrong mask, a missed clear, or a register that a faulting write should have left alone shows up at the next readback of that index. That readback comes within one sweep of 64 reads.

A strobe decoded to the wrong index shows up as a wrong `ctl_pulse` bit one edge after the write. A pulse that is held too long shows up one edge after that. A stuck or skipping tick counter shows up as the wrong difference between cycle-counter reads that are one clock and eleven clocks apart.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

  localparam int DATA_W      = 64;
  localparam int IDX_W       = 6;
  localparam int HALF_W      = DATA_W / 2;

  localparam int IDX_EXC_ADDR  = 10;
  localparam int IDX_IPL       = 11;
  localparam int IDX_SWINT     = 12;
  localparam int IDX_MODE_I    = 13;
  localparam int IDX_MODE_D    = 14;
  localparam int IDX_TRAP_REQ  = 15;
  localparam int IDX_TRAP_EN   = 16;
  localparam int IDX_EXC_SUM   = 17;
  localparam int IDX_EXC_MASK  = 18;
  localparam int IDX_ICTL      = 19;
  localparam int IDX_IPTBR     = 20;
  localparam int IDX_DPTBR     = 21;
  localparam int IDX_DC_TEST   = 22;
  localparam int IDX_DC_MODE   = 23;
  localparam int IDX_MISS_MODE = 24;
  localparam int IDX_IASN      = 25;
  localparam int IDX_DASN      = 26;
  localparam int IDX_CYCLE     = 27;
  localparam int NUM_STORED    = 28;
  localparam int IDX_RO0       = 28;
  localparam int NUM_RO        = 5;
  localparam int IDX_WO0       = IDX_RO0 + NUM_RO;
  localparam int NUM_WO        = 6;
  localparam int IDX_LIMIT     = IDX_WO0 + NUM_WO;

  typedef enum logic [2:0] {
    ROLE_STORE,
    ROLE_CLEAR,
    ROLE_RDONLY,
    ROLE_WRONLY,
    ROLE_CYCLE,
    ROLE_NONE
  } role_t;

  function automatic role_t role_of(int i);
    role_t r;
    if (i == IDX_EXC_SUM || i == IDX_EXC_MASK) r = ROLE_CLEAR;
    else if (i == IDX_CYCLE)                   r = ROLE_CYCLE;
    else if (i < NUM_STORED)                   r = ROLE_STORE;
    else if (i < IDX_RO0 + NUM_RO)             r = ROLE_RDONLY;
    else if (i < IDX_WO0 + NUM_WO)             r = ROLE_WRONLY;
    else                                       r = ROLE_NONE;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] wmask_of(int i);
    logic [DATA_W-1:0] m;
    case (i)
      IDX_EXC_ADDR:               m = ~64'h2;
      IDX_IPL:                    m = 64'h1f;
      IDX_SWINT:                  m = 64'h7fff0;
      IDX_MODE_I, IDX_MODE_D:     m = 64'h18;
      IDX_TRAP_REQ, IDX_TRAP_EN:  m = 64'hf;
      IDX_ICTL:                   m = 64'hff_ffff_0300;
      IDX_IPTBR, IDX_DPTBR:       m = 64'hffff_ffff_c000_0000;
      IDX_DC_TEST:                m = 64'h1ffb;
      IDX_DC_MODE, IDX_MISS_MODE: m = 64'h3f;
      IDX_IASN:                   m = 64'h7f0;
      IDX_DASN:                   m = 64'hfe00_0000_0000_0000;
      default:                    m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ctl_regbank_decode.sv
module ctl_regbank_decode
  import ctl_regbank_pkg::*;
#(
  parameter bit IS_WRITE = 1'b0
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output role_t            role,
  output logic             bad
);

  logic forbidden;

  always_comb begin
    role = role_of(int'(idx));
    if (IS_WRITE) forbidden = (role == ROLE_RDONLY);
    else          forbidden = (role == ROLE_WRONLY);
    bad = en && (forbidden || role == ROLE_NONE);
  end

endmodule

// File: rtl/ctl_regbank_store.sv
module ctl_regbank_store
  import ctl_regbank_pkg::*;
#(
  parameter int ENTRIES = NUM_STORED,
  parameter int WIDTH   = DATA_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            commit,
  input  logic [IDX_W-1:0]                idx,
  input  logic [WIDTH-1:0]                data,
  output logic [ENTRIES-1:0][WIDTH-1:0]   q
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam role_t             ROLE = role_of(e);
    localparam logic [WIDTH-1:0]  MASK = WIDTH'(wmask_of(e));
    logic             hit;
    logic [WIDTH-1:0] d;

    always_comb begin
      hit = commit && (idx == IDX_W'(e));
      d   = (ROLE == ROLE_CLEAR) ? '0 : (data & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q[e] <= '0;
      else if (hit) q[e] <= d;
    end
  end

endmodule

// File: rtl/ctl_regbank_tick.sv
module ctl_regbank_tick #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] count_d;

  always_comb count_d = count + WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (run) count <= count_d;
  end

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              fault,
  output logic [NUM_WO-1:0] ctl_pulse
);

  logic                               rst_meta_n;
  logic                               rst_q_n;
  role_t                              wr_role;
  role_t                              rd_role;
  logic                               wr_bad;
  logic                               rd_bad;
  logic                               wr_commit;
  logic [NUM_STORED-1:0][DATA_W-1:0]  store_q;
  logic [HALF_W-1:0]                  tick_q;
  logic [DATA_W-1:0]                  stored_sel;
  logic [DATA_W-1:0]                  rd_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  ctl_regbank_decode #(.IS_WRITE(1'b1)) u_wr_dec (
    .en   (wr_en),
    .idx  (wr_idx),
    .role (wr_role),
    .bad  (wr_bad)
  );

  ctl_regbank_decode #(.IS_WRITE(1'b0)) u_rd_dec (
    .en   (rd_en),
    .idx  (rd_idx),
    .role (rd_role),
    .bad  (rd_bad)
  );

  always_comb begin
    wr_commit = wr_en && !wr_bad && (wr_role != ROLE_WRONLY);
    fault     = wr_bad || rd_bad;
  end

  ctl_regbank_store #(.ENTRIES(NUM_STORED), .WIDTH(DATA_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .commit (wr_commit),
    .idx    (wr_idx),
    .data   (wr_data),
    .q      (store_q)
  );

  ctl_regbank_tick #(.WIDTH(HALF_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_q_n),
    .run   (1'b1),
    .count (tick_q)
  );

  always_comb begin
    stored_sel = '0;
    for (int k = 0; k < NUM_STORED; k++) begin
      if (rd_idx == IDX_W'(k)) stored_sel = store_q[k];
    end
    case (rd_role)
      ROLE_STORE, ROLE_CLEAR: rd_val = stored_sel;
      ROLE_CYCLE:             rd_val = {stored_sel[DATA_W-1:HALF_W], tick_q};
      default:                rd_val = '0;
    endcase
    rd_data = (rd_en && !rd_bad) ? rd_val : '0;
  end

  for (genvar s = 0; s < NUM_WO; s++) begin : g_strobe
    logic pulse_d;
    always_comb pulse_d = wr_en && (wr_idx == IDX_W'(IDX_WO0 + s));
    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) ctl_pulse[s] <= 1'b0;
      else          ctl_pulse[s] <= pulse_d;
    end
  end

endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DATA_W-1:0] rd_data,
  input logic              fault,
  input logic [NUM_WO-1:0] ctl_pulse
);

  AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0(ctl_pulse)); // R9

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (|ctl_pulse) |-> ($past(wr_en) && ($past(wr_idx) >= IDX_W'(IDX_WO0)))); // R9

  AST_EXCADDR_BIT1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && rd_idx == IDX_W'(IDX_EXC_ADDR)) |-> !rd_data[1]); // R3

  AST_IPL_FIELD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && rd_idx == IDX_W'(IDX_IPL)) |-> (rd_data[DATA_W-1:5] == '0)); // R4

  AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(wr_en && wr_idx == IDX_W'(IDX_EXC_SUM)) && rd_en && rd_idx == IDX_W'(IDX_EXC_SUM))
    |-> (rd_data == '0)); // R6

  AST_WRONLY_READ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && rd_idx >= IDX_W'(IDX_WO0) && rd_idx < IDX_W'(IDX_LIMIT))
    |-> (fault && rd_data == '0)); // R8

  AST_UNASSIGNED_FAULT: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((rd_en && rd_idx >= IDX_W'(IDX_LIMIT)) || (wr_en && wr_idx >= IDX_W'(IDX_LIMIT)))
    |-> fault); // R10

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && rd_idx == IDX_W'(IDX_CYCLE) && $past(rst_q_n)
     && $past(rd_en && rd_idx == IDX_W'(IDX_CYCLE)))
    |-> (rd_data[HALF_W-1:0] == HALF_W'($past(rd_data[HALF_W-1:0]) + 1))); // R11

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_en |-> (rd_data == '0)); // R12

endmodule

bind ctl_regbank ctl_regbank_chk i_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .rd_en     (rd_en),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .fault     (fault),
  .ctl_pulse (ctl_pulse)
);

// File: tb/test_ctl_regbank.sv
`timescale 1ns/1ps
module test_ctl_regbank;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_idx;
  logic [63:0] wr_data;
  logic        rd_en;
  logic [5:0]  rd_idx;
  logic [63:0] rd_data;
  logic        fault;
  logic [5:0]  ctl_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [63:0] model [64];

  ctl_regbank i_ctl_regbank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .fault(fault), .ctl_pulse(ctl_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // kinds: 0 stored/masked, 1 clear, 2 read-only, 3 write-only, 4 unassigned, 5 cycle
  function automatic int kind_of(int i);
    if (i == 17 || i == 18) return 1;
    if (i == 27) return 5;
    if (i < 28) return 0;
    if (i < 33) return 2;
    if (i < 39) return 3;
    return 4;
  endfunction

  function automatic logic [63:0] mask_of(int i);
    case (i)
      10: return ~64'h2;
      11: return 64'h1f;
      12: return 64'h7fff0;
      13, 14: return 64'h18;
      15, 16: return 64'hf;
      19: return 64'hff_ffff_0300;
      20, 21: return 64'hffff_ffff_c000_0000;
      22: return 64'h1ffb;
      23, 24: return 64'h3f;
      25: return 64'h7f0;
      26: return 64'hfe00_0000_0000_0000;
      default: return '1;
    endcase
  endfunction

  function automatic string req_of(int i);
    case (kind_of(i))
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R10";
      5: return "R11";
      default: return (i < 10) ? "R2" : (i == 10) ? "R3" : (i < 17) ? "R4" : "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(int i, logic [63:0] d);
    int k = kind_of(i);
    bit exp_f = (k == 2 || k == 4);
    logic [5:0] exp_p = (k == 3) ? 6'(1 << (i - 33)) : 6'd0;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'(i); wr_data = d;
    #1;
    chk(fault == exp_f, exp_f ? (k == 2 ? "R7" : "R10") : "R12", $sformatf("write fault idx %0d", i),
        64'(fault), 64'(exp_f));
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk(ctl_pulse == exp_p, "R9", $sformatf("pulse after write idx %0d", i), 64'(ctl_pulse), 64'(exp_p));
    if (k == 0)      model[i] = d & mask_of(i);
    else if (k == 1) model[i] = '0;
    else if (k == 5) model[i] = d;
  endtask

  task automatic do_read(int i);
    int k = kind_of(i);
    bit exp_f = (k == 3 || k == 4);
    logic [63:0] exp_d = (k == 0 || k == 1) ? model[i] : 64'd0;
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 6'(i);
    #1;
    chk(fault == exp_f, exp_f ? req_of(i) : "R12", $sformatf("read fault idx %0d", i), 64'(fault), 64'(exp_f));
    if (k == 5)
      chk(rd_data[63:32] == model[i][63:32], "R11", "cycle upper half",
          64'(rd_data[63:32]), 64'(model[i][63:32]));
    else
      chk(rd_data == exp_d, req_of(i), $sformatf("read data idx %0d", i), rd_data, exp_d);
    @(posedge clk); #1;
    rd_en = 1'b0;
    chk(ctl_pulse == 6'd0, "R9", "pulse lasts one cycle", 64'(ctl_pulse), 64'd0);
  endtask

  initial begin
    logic [63:0] a, b;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_en = 1'b0; rd_idx = '0;
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(fault == 1'b0, "R1", "fault idle after reset", 64'(fault), 64'd0);
    chk(ctl_pulse == 6'd0, "R1", "pulses idle after reset", 64'(ctl_pulse), 64'd0);
    chk(rd_data == 64'd0, "R12", "idle read data", rd_data, 64'd0);
    // R1: reset contents of the whole bank
    for (int i = 0; i < 64; i++) do_read(i);

    // sweeps: write every index, then read back the whole bank
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 64; i++) begin
        logic [63:0] d;
        case (p)
          0: d = '1;
          1: d = 64'h0123_4567_89ab_cdef ^ (64'(i) * 64'h0101_0101_0101_0101);
          2: d = 64'hfedc_ba98_7654_3210 + 64'(i);
          default: d = 64'h5555_aaaa_3333_cccc ^ {64'(i), 58'd0};
        endcase
        do_write(i, d);
      end
      for (int i = 0; i < 64; i++) do_read(i);
    end

    // R6: clear-on-write after a stored value cannot exist, so exercise with nonzero data again
    do_write(17, '1);
    do_read(17);

    // R12: read in the same cycle as a write to that index returns the old value
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd3; wr_data = 64'h1111_2222_3333_4444;
    rd_en = 1'b1; rd_idx = 6'd3;
    #1;
    chk(rd_data == model[3], "R12", "read old value during write", rd_data, model[3]);
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    model[3] = 64'h1111_2222_3333_4444;
    do_read(3);

    // R11: tick counter advances one per clock
    do_write(27, 64'h1234_5678_9abc_def0);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 6'd27;
    #1; a = rd_data;
    @(negedge clk); #1; b = rd_data;
    chk(b[31:0] == a[31:0] + 32'd1, "R11", "tick step of one", 64'(b[31:0]), 64'(a[31:0] + 32'd1));
    repeat (10) @(negedge clk);
    #1; b = rd_data;
    chk(b[31:0] == a[31:0] + 32'd11, "R11", "tick after eleven clocks", 64'(b[31:0]), 64'(a[31:0] + 32'd11));
    chk(b[63:32] == 32'h1234_5678, "R11", "cycle upper half", 64'(b[63:32]), 64'h1234_5678);
    rd_en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule